// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps the pointer and the occupancy map of a rotating register window laid over a physical register file of `NAREG` registers, organised as `NAREG/4` groups of four. A window pointer selects which group logical register 0 lands on, and an occupancy vector holds one bit per group, marking the groups that start a live call frame. The processor pipeline sends one request per instruction that touches the window: a call-entry frame allocation, a windowed return, an absolute pointer write, a relative rotation, a restore from a saved pointer, or a dynamic stack allocation check. The block updates its state and answers each request with a verdict: accepted, illegal, window overflow (4, 8 or 12 registers to spill) or underflow (4, 8 or 12 registers to fill). The spill and fill handlers live elsewhere. Those handlers use the reported pre-request pointer and the trap program counter.

Requests arrive on a valid/ready channel and the verdicts leave on a second valid/ready channel with one register stage. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. A response that is not taken stays unchanged on the output until `rsp_ready` is high. The window state updates on the edge that accepts a request, so while a response is shown, `win_base` and `win_start` show the state after that request. A combinational lookup port turns a logical register number into its physical index.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window pointer is 0, the occupancy vector holds only bit 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `map_preg` equals (4*`win_base` + `map_lreg`) modulo `NAREG`, wrapping over the end of the physical file.
- R3: A call-entry request (op code 0) is illegal (kind 1) when `req_sel` exceeds 3, when `req_woe` is 0 or when `req_excm` is 1. The pointer and the occupancy vector are left unchanged.
- R4: A legal call-entry with increment c = `req_callinc` and no occupied group among pointer+1 up to pointer+c reports kind 0. It asserts `rsp_wr_en` with index {c, `req_sel[1:0]`} and data `req_sp` minus 8*`req_imm`. It then adds c to the pointer and sets the occupancy bit of the new pointer.
- R5: On a legal call-entry where some group among pointer+1 up to pointer+c is occupied, let n be the distance to the nearest one. The pointer advances by n and the occupancy vector is unchanged. The kind is overflow-4 (2) if group new pointer+1 is occupied, otherwise overflow-8 (3) if new pointer+2 is occupied, otherwise overflow-12 (4).
- R6: A return (op code 1) takes n from `req_a0[31:30]` and m as the distance to the nearest occupied group among pointer-1, pointer-2, pointer-3 (0 if none). It is illegal with no state change when n is 0, when m is nonzero and unequal to n, when `req_woe` is 0 or when `req_excm` is 1.
- R7: A legal return whose group at pointer-n is occupied reports kind 0. It subtracts n from the pointer, clears the old pointer's occupancy bit and returns `rsp_pc` = {`req_pc[31:30]`, `req_a0[29:0]`}.
- R8: A legal return whose group at pointer-n is free subtracts n from the pointer and keeps the occupancy vector. It reports underflow-4 (5), underflow-8 (6) or underflow-12 (7) for n of 1, 2 or 3, with `rsp_pc` = `req_pc`.
- R9: An allocation check (op code 5) reports kind 8 when the groups at pointer-1, pointer-2 and pointer-3 are all free, and kind 0 otherwise, with no state change.
- R10: Pointer write (op code 2) and restore (op code 4) load `req_arg`. Rotate (op code 3) adds `req_arg` modulo `NAREG/4`. All three report kind 0 and leave the occupancy vector unchanged.
- R11: `req_ready` is 1 exactly when the output stage is empty or `rsp_ready` is 1. A response held with `rsp_ready` low keeps all its fields stable, and no new request is taken meanwhile.
- R12: Each accepted request yields exactly one response. `rsp_owb` carries the pointer before the request, `rsp_excm` is 1 for every kind except 0, `rsp_pc` is `req_pc` unless R7 applies, and op codes 6 and 7 are illegal with no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 3 | Request op code |
| req_pc | input | 32 | Program counter of the instruction |
| req_a0 | input | 32 | Return-address register value (return) |
| req_sp | input | 32 | Stack-register value (call-entry) |
| req_sel | input | 4 | Stack-register selector (call-entry) |
| req_imm | input | IMM_W (12) | Frame size in 8-byte units (call-entry) |
| req_woe | input | 1 | Window overflow enable from the status word |
| req_excm | input | 1 | Exception mode from the status word |
| req_callinc | input | 2 | Call increment from the status word |
| req_arg | input | WB_W (4) | Pointer value or rotation amount |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken on this edge when valid |
| rsp_kind | output | 4 | Verdict code |
| rsp_pc | output | 32 | Return target or trap program counter |
| rsp_wr_en | output | 1 | Write stack value into the register file |
| rsp_wr_idx | output | 4 | Logical register to write (pre-rotation window) |
| rsp_wr_data | output | 32 | New stack value |
| rsp_owb | output | WB_W (4) | Window pointer before the request |
| rsp_excm | output | 1 | Set exception mode (every non-zero verdict) |
| win_base | output | WB_W (4) | Current window pointer |
| win_start | output | NAREG/4 (16) | Current occupancy vector |
| map_lreg | input | 4 | Logical register to translate |
| map_preg | output | PR_W (6) | Physical register index |

## Verification
A wrong pointer or occupancy bit inside the block shows on `win_base`/`win_start` in the same cycle as the response of the request that caused it. It also spoils the next window-sensitive verdict. A stale occupancy bit turns a later return into an illegal or underflow verdict, or a later call-entry into an overflow of the wrong size, one request later. A wrong physical mapping shows on `map_preg` at once. The sequence therefore builds frames across the wrap of the pointer and then returns through them, so each error of state reaches a verdict within a request or two.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;

  typedef enum logic [2:0] {
    OP_ENTRY   = 3'd0,
    OP_RETURN  = 3'd1,
    OP_SETBASE = 3'd2,
    OP_ROTATE  = 3'd3,
    OP_RESTORE = 3'd4,
    OP_ALLOCA  = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    K_OK      = 4'd0,
    K_ILLEGAL = 4'd1,
    K_OVF4    = 4'd2,
    K_OVF8    = 4'd3,
    K_OVF12   = 4'd4,
    K_UNF4    = 4'd5,
    K_UNF8    = 4'd6,
    K_UNF12   = 4'd7,
    K_ALLOCA  = 4'd8
  } kind_e;

endpackage

// File: rtl/regwin_state.sv
`timescale 1ns/1ps
module regwin_state #(
  parameter int NGRP = 16,
  parameter int WB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [WB_W-1:0] base_d,
  input  logic [NGRP-1:0] start_d,
  output logic [WB_W-1:0] base_q,
  output logic [NGRP-1:0] start_q
);

  localparam logic [NGRP-1:0] START_RST = NGRP'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= START_RST;
    end else if (load_i) begin
      base_q  <= base_d;
      start_q <= start_d;
    end
  end

endmodule

// File: rtl/regwin_entry_eval.sv
`timescale 1ns/1ps
module regwin_entry_eval
  import regwin_pkg::*;
#(
  parameter int NGRP  = 16,
  parameter int WB_W  = 4,
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic [WB_W-1:0]  base_i,
  input  logic [NGRP-1:0]  start_i,
  input  logic [3:0]       sel_i,
  input  logic             woe_i,
  input  logic             excm_i,
  input  logic [1:0]       callinc_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [IMM_W-1:0] imm_i,
  output kind_e            kind_o,
  output logic [WB_W-1:0]  base_o,
  output logic [NGRP-1:0]  start_o,
  output logic             wr_en_o,
  output logic [3:0]       wr_idx_o,
  output logic [XLEN-1:0]  wr_data_o
);

  // groups above the pointer: ahead[k] is the group at base+1+k
  localparam int LOOK = 5;
  logic [LOOK-1:0] ahead;

  for (genvar k = 0; k < LOOK; k++) begin : g_ahead
    assign ahead[k] = start_i[base_i + WB_W'(k + 1)];
  end

  logic [1:0] first;
  logic       illegal;

  always_comb begin
    first = 2'd0;
    for (int k = 2; k >= 0; k--) begin
      if ((2'(k) < callinc_i) && ahead[k]) first = 2'(k + 1);
    end
  end

  assign illegal   = (sel_i[3:2] != 2'b00) || !woe_i || excm_i;
  assign wr_idx_o  = {callinc_i, sel_i[1:0]};
  assign wr_data_o = sp_i - (XLEN'(imm_i) << 3);

  always_comb begin
    kind_o  = K_OK;
    base_o  = base_i;
    start_o = start_i;
    wr_en_o = 1'b0;
    if (illegal) begin
      kind_o = K_ILLEGAL;
    end else if (first != 2'd0) begin
      base_o = base_i + WB_W'(first);
      if (ahead[first])                 kind_o = K_OVF4;
      else if (ahead[3'(first) + 3'd1]) kind_o = K_OVF8;
      else                              kind_o = K_OVF12;
    end else begin
      wr_en_o = 1'b1;
      base_o  = base_i + WB_W'(callinc_i);
      start_o[base_i + WB_W'(callinc_i)] = 1'b1;
    end
  end

endmodule

// File: rtl/regwin_return_eval.sv
`timescale 1ns/1ps
module regwin_return_eval
  import regwin_pkg::*;
#(
  parameter int NGRP = 16,
  parameter int WB_W = 4,
  parameter int XLEN = 32
) (
  input  logic [WB_W-1:0] base_i,
  input  logic [NGRP-1:0] start_i,
  input  logic [XLEN-1:0] a0_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            woe_i,
  input  logic            excm_i,
  output kind_e           kind_o,
  output logic [WB_W-1:0] base_o,
  output logic [NGRP-1:0] start_o,
  output logic [XLEN-1:0] ret_pc_o,
  output logic            alloca_fault_o
);

  // groups below the pointer: behind[j] is the group at base-1-j
  localparam int BACK = 3;
  logic [BACK-1:0] behind;

  for (genvar j = 0; j < BACK; j++) begin : g_behind
    assign behind[j] = start_i[base_i - WB_W'(j + 1)];
  end

  logic [1:0]      n_inc;
  logic [1:0]      m_own;
  logic [WB_W-1:0] target;
  logic            illegal;

  assign n_inc  = a0_i[XLEN-1:XLEN-2];
  assign target = base_i - WB_W'(n_inc);

  always_comb begin
    if (behind[0])      m_own = 2'd1;
    else if (behind[1]) m_own = 2'd2;
    else if (behind[2]) m_own = 2'd3;
    else                m_own = 2'd0;
  end

  assign alloca_fault_o = ~|behind;
  assign illegal  = (n_inc == 2'd0) || ((m_own != 2'd0) && (m_own != n_inc)) ||
                    !woe_i || excm_i;
  assign ret_pc_o = {pc_i[XLEN-1:XLEN-2], a0_i[XLEN-3:0]};

  always_comb begin
    kind_o  = K_OK;
    base_o  = base_i;
    start_o = start_i;
    if (illegal) begin
      kind_o = K_ILLEGAL;
    end else begin
      base_o = target;
      if (start_i[target]) begin
        start_o[base_i] = 1'b0;
      end else begin
        case (n_inc)
          2'd1:    kind_o = K_UNF4;
          2'd2:    kind_o = K_UNF8;
          default: kind_o = K_UNF12;
        endcase
      end
    end
  end

endmodule

// File: rtl/regwin_ctrl.sv
`timescale 1ns/1ps
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  localparam int NGRP = NAREG / 4,
  localparam int WB_W = $clog2(NGRP),
  localparam int PR_W = $clog2(NAREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [XLEN-1:0]  req_pc,
  input  logic [XLEN-1:0]  req_a0,
  input  logic [XLEN-1:0]  req_sp,
  input  logic [3:0]       req_sel,
  input  logic [IMM_W-1:0] req_imm,
  input  logic             req_woe,
  input  logic             req_excm,
  input  logic [1:0]       req_callinc,
  input  logic [WB_W-1:0]  req_arg,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [3:0]       rsp_kind,
  output logic [XLEN-1:0]  rsp_pc,
  output logic             rsp_wr_en,
  output logic [3:0]       rsp_wr_idx,
  output logic [XLEN-1:0]  rsp_wr_data,
  output logic [WB_W-1:0]  rsp_owb,
  output logic             rsp_excm,
  output logic [WB_W-1:0]  win_base,
  output logic [NGRP-1:0]  win_start,
  input  logic [3:0]       map_lreg,
  output logic [PR_W-1:0]  map_preg
);

  logic            acc;
  logic [WB_W-1:0] base_q, nbase;
  logic [NGRP-1:0] start_q, nstart;

  kind_e           ent_kind, ret_kind, nk, kind_q;
  logic [WB_W-1:0] ent_base, ret_base;
  logic [NGRP-1:0] ent_start, ret_start;
  logic            ent_wr, nwr;
  logic [3:0]      ent_idx;
  logic [XLEN-1:0] ent_data, ret_pc, npc;
  logic            alloca_fault;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  regwin_state #(.NGRP(NGRP), .WB_W(WB_W)) state_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (acc),
    .base_d  (nbase),
    .start_d (nstart),
    .base_q  (base_q),
    .start_q (start_q)
  );

  regwin_entry_eval #(.NGRP(NGRP), .WB_W(WB_W), .XLEN(XLEN), .IMM_W(IMM_W)) entry_i (
    .base_i    (base_q),
    .start_i   (start_q),
    .sel_i     (req_sel),
    .woe_i     (req_woe),
    .excm_i    (req_excm),
    .callinc_i (req_callinc),
    .sp_i      (req_sp),
    .imm_i     (req_imm),
    .kind_o    (ent_kind),
    .base_o    (ent_base),
    .start_o   (ent_start),
    .wr_en_o   (ent_wr),
    .wr_idx_o  (ent_idx),
    .wr_data_o (ent_data)
  );

  regwin_return_eval #(.NGRP(NGRP), .WB_W(WB_W), .XLEN(XLEN)) return_i (
    .base_i         (base_q),
    .start_i        (start_q),
    .a0_i           (req_a0),
    .pc_i           (req_pc),
    .woe_i          (req_woe),
    .excm_i         (req_excm),
    .kind_o         (ret_kind),
    .base_o         (ret_base),
    .start_o        (ret_start),
    .ret_pc_o       (ret_pc),
    .alloca_fault_o (alloca_fault)
  );

  // select the outcome of the request by op code
  always_comb begin
    nk     = K_OK;
    nbase  = base_q;
    nstart = start_q;
    npc    = req_pc;
    nwr    = 1'b0;
    case (req_op)
      OP_ENTRY: begin
        nk     = ent_kind;
        nbase  = ent_base;
        nstart = ent_start;
        nwr    = ent_wr;
      end
      OP_RETURN: begin
        nk     = ret_kind;
        nbase  = ret_base;
        nstart = ret_start;
        if (ret_kind == K_OK) npc = ret_pc;
      end
      OP_SETBASE, OP_RESTORE: nbase = req_arg;
      OP_ROTATE:              nbase = base_q + req_arg;
      OP_ALLOCA: if (alloca_fault) nk = K_ALLOCA;
      default:                nk = K_ILLEGAL;
    endcase
  end

  // response output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      kind_q      <= K_OK;
      rsp_pc      <= '0;
      rsp_wr_en   <= 1'b0;
      rsp_wr_idx  <= '0;
      rsp_wr_data <= '0;
      rsp_owb     <= '0;
      rsp_excm    <= 1'b0;
    end else if (acc) begin
      rsp_valid   <= 1'b1;
      kind_q      <= nk;
      rsp_pc      <= npc;
      rsp_wr_en   <= nwr;
      rsp_wr_idx  <= ent_idx;
      rsp_wr_data <= ent_data;
      rsp_owb     <= base_q;
      rsp_excm    <= (nk != K_OK);
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  assign rsp_kind  = kind_q;
  assign win_base  = base_q;
  assign win_start = start_q;
  assign map_preg  = PR_W'({base_q, 2'b00}) + PR_W'(map_lreg);

  // R11: a held response does not move
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_pc)
      && $stable(rsp_wr_data) && $stable(rsp_owb));

  // R3: illegal call-entry keeps the window state
  p_entry_ill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_op == OP_ENTRY) && ((req_sel > 4'd3) || !req_woe || req_excm)
      |=> $stable(base_q) && $stable(start_q) && (rsp_kind == K_ILLEGAL));

  // R4: accepted entry marks the new pointer as occupied
  p_entry_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_op == OP_ENTRY) && (ent_kind == K_OK) |=> start_q[base_q]);

  // R4: the stack write only goes with an accepted verdict
  p_wr_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wr_en |-> (rsp_kind == K_OK));

  // R5: after a 4-register overflow both the new group and the next are occupied
  p_ovf4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_kind == K_OVF4) |-> start_q[base_q] && start_q[base_q + WB_W'(1)]);

  // R7: a good return frees the group it left
  p_ret_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_op == OP_RETURN) && (ret_kind == K_OK) |=> !start_q[$past(base_q)]);

  // R8: after an underflow the new pointer's group is free
  p_unf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && ((rsp_kind == K_UNF4) || (rsp_kind == K_UNF8) || (rsp_kind == K_UNF12))
      |-> !start_q[base_q]);

endmodule

// File: tb/regwin_ctrl_tb_top.sv
`timescale 1ns/1ps
module regwin_ctrl_tb_top;

  localparam int NAREG = 64;
  localparam int NG    = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_op;
  logic [31:0] req_pc, req_a0, req_sp;
  logic [3:0]  req_sel;
  logic [11:0] req_imm;
  logic        req_woe, req_excm;
  logic [1:0]  req_callinc;
  logic [3:0]  req_arg;
  logic        rsp_valid, rsp_ready;
  logic [3:0]  rsp_kind;
  logic [31:0] rsp_pc;
  logic        rsp_wr_en;
  logic [3:0]  rsp_wr_idx;
  logic [31:0] rsp_wr_data;
  logic [3:0]  rsp_owb;
  logic        rsp_excm;
  logic [3:0]  win_base;
  logic [15:0] win_start;
  logic [3:0]  map_lreg;
  logic [5:0]  map_preg;

  always #2 clk = ~clk;

  regwin_ctrl #(.NAREG(NAREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_pc(req_pc), .req_a0(req_a0), .req_sp(req_sp),
    .req_sel(req_sel), .req_imm(req_imm), .req_woe(req_woe), .req_excm(req_excm),
    .req_callinc(req_callinc), .req_arg(req_arg), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_pc(rsp_pc),
    .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx), .rsp_wr_data(rsp_wr_data),
    .rsp_owb(rsp_owb), .rsp_excm(rsp_excm), .win_base(win_base),
    .win_start(win_start), .map_lreg(map_lreg), .map_preg(map_preg)
  );

  typedef struct {
    int          kind;
    logic [31:0] pc;
    logic        wr_en;
    logic [3:0]  idx;
    logic [31:0] data;
    logic [3:0]  owb;
    logic [3:0]  base;
    logic [15:0] start;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad   = 0;
  logic [3:0]  m_base;
  logic [15:0] m_start;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference model, written from the requirements
  task automatic predict(input logic [2:0] op, input logic [3:0] arg, input logic [31:0] pc,
                         input logic [31:0] a0, input logic [31:0] sp, input logic [3:0] sel,
                         input logic [11:0] imm, input logic woe, input logic excm,
                         input logic [1:0] ci, input string tag, output exp_t e);
    int b, nb, n, m;
    b = int'(m_base);
    e.kind = 0; e.pc = pc; e.wr_en = 1'b0; e.idx = 4'd0; e.data = 32'd0;
    e.owb = m_base; e.tag = tag;
    nb = b;
    case (op)
      3'd0: begin
        if (sel > 4'd3 || !woe || excm) e.kind = 1;
        else begin
          n = 0;
          for (int i = 1; i <= int'(ci); i++) if (n == 0 && m_start[(b + i) % NG]) n = i;
          if (n != 0) begin
            nb = (b + n) % NG;
            if (m_start[(nb + 1) % NG])      e.kind = 2;
            else if (m_start[(nb + 2) % NG]) e.kind = 3;
            else                             e.kind = 4;
          end else begin
            e.wr_en = 1'b1; e.idx = {ci, sel[1:0]};
            e.data = sp - {imm, 3'b000};
            nb = (b + int'(ci)) % NG;
            m_start[nb] = 1'b1;
          end
        end
      end
      3'd1: begin
        n = int'(a0[31:30]); m = 0;
        for (int j = 1; j <= 3; j++) if (m == 0 && m_start[(b - j + NG) % NG]) m = j;
        if (n == 0 || (m != 0 && m != n) || !woe || excm) e.kind = 1;
        else begin
          nb = (b - n + NG) % NG;
          if (m_start[nb]) begin
            m_start[b] = 1'b0;
            e.pc = {pc[31:30], a0[29:0]};
          end else e.kind = 4 + n;
        end
      end
      3'd2, 3'd4: nb = int'(arg);
      3'd3: nb = (b + int'(arg)) % NG;
      3'd5: if (!m_start[(b + NG - 1) % NG] && !m_start[(b + NG - 2) % NG] &&
                !m_start[(b + NG - 3) % NG]) e.kind = 8;
      default: e.kind = 1;
    endcase
    m_base = 4'(nb);
    e.base = m_base; e.start = m_start;
  endtask

  // driver: one request, expected item queued when it is accepted
  task automatic send(input logic [2:0] op, input logic [3:0] arg, input logic [31:0] pc,
                      input logic [31:0] a0, input logic [31:0] sp, input logic [3:0] sel,
                      input logic [11:0] imm, input logic woe, input logic excm,
                      input logic [1:0] ci, input string tag);
    exp_t e;
    @(negedge clk);
    req_op = op; req_arg = arg; req_pc = pc; req_a0 = a0; req_sp = sp; req_sel = sel;
    req_imm = imm; req_woe = woe; req_excm = excm; req_callinc = ci; req_valid = 1'b1;
    predict(op, arg, pc, a0, sp, sel, imm, woe, excm, ci, tag, e);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic entry(input logic [1:0] ci, input logic [3:0] sel, input logic [31:0] sp,
                       input logic [11:0] imm, input logic woe, input logic excm,
                       input logic [31:0] pc, input string tag);
    send(3'd0, 4'd0, pc, 32'd0, sp, sel, imm, woe, excm, ci, tag);
  endtask

  task automatic retw(input logic [31:0] a0, input logic [31:0] pc, input logic woe,
                      input logic excm, input string tag);
    send(3'd1, 4'd0, pc, a0, 32'd0, 4'd0, 12'd0, woe, excm, 2'd0, tag);
  endtask

  task automatic simple(input logic [2:0] op, input logic [3:0] arg, input string tag);
    send(op, arg, 32'h0000_5550 + 32'(arg), 32'd0, 32'd0, 4'd0, 12'd0, 1'b1, 1'b0, 2'd0, tag);
  endtask

  // monitor: compare each delivered response with the head of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) chk("R12", "response without request", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.tag, "kind", 32'(rsp_kind), 32'(e.kind));
          chk(e.tag, "pc", rsp_pc, e.pc);
          chk(e.tag, "wr_en", 32'(rsp_wr_en), 32'(e.wr_en));
          if (e.wr_en) begin
            chk(e.tag, "wr_idx", 32'(rsp_wr_idx), 32'(e.idx));
            chk(e.tag, "wr_data", rsp_wr_data, e.data);
          end
          chk("R12", "owb", 32'(rsp_owb), 32'(e.owb));
          chk("R12", "excm", 32'(rsp_excm), 32'(e.kind != 0));
          chk(e.tag, "win_base", 32'(win_base), 32'(e.base));
          chk(e.tag, "win_start", 32'(win_start), 32'(e.start));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1; map_lreg = 4'd0;
    req_op = 3'd0; req_arg = 4'd0; req_pc = 32'd0; req_a0 = 32'd0; req_sp = 32'd0;
    req_sel = 4'd0; req_imm = 12'd0; req_woe = 1'b0; req_excm = 1'b0; req_callinc = 2'd0;
    m_base = 4'd0; m_start = 16'h0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "win_base", 32'(win_base), 32'd0);
    chk("R1", "win_start", 32'(win_start), 32'h0001);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);

    @(negedge clk); map_lreg = 4'd5; #1;
    chk("R2", "map_preg", 32'(map_preg), 32'd5);

    // R3 illegal call-entries
    entry(2'd1, 4'd4, 32'h1000, 12'd2, 1'b1, 1'b0, 32'h100, "R3");
    entry(2'd1, 4'd1, 32'h1000, 12'd2, 1'b0, 1'b0, 32'h104, "R3");
    entry(2'd1, 4'd1, 32'h1000, 12'd2, 1'b1, 1'b1, 32'h108, "R3");
    // R4 legal entries: 0 -> 1 -> 3 -> 6, and a zero increment
    entry(2'd1, 4'd1, 32'h1000, 12'd2, 1'b1, 1'b0, 32'h10c, "R4");
    entry(2'd2, 4'd3, 32'h2000, 12'd16, 1'b1, 1'b0, 32'h110, "R4");
    entry(2'd3, 4'd0, 32'h0000_0010, 12'd4, 1'b1, 1'b0, 32'h114, "R4");
    entry(2'd0, 4'd2, 32'h3000, 12'hfff, 1'b1, 1'b0, 32'h118, "R4");
    // R10 pointer write to 15, R2 mapping wraps
    simple(3'd2, 4'd15, "R10");
    map_lreg = 4'd7; #1;
    chk("R2", "map_preg wrap", 32'(map_preg), 32'd3);
    // R5 overflows of each size across the wrap
    entry(2'd1, 4'd1, 32'h4000, 12'd1, 1'b1, 1'b0, 32'h200, "R5");
    entry(2'd2, 4'd1, 32'h4000, 12'd1, 1'b1, 1'b0, 32'h204, "R5");
    entry(2'd3, 4'd1, 32'h4000, 12'd1, 1'b1, 1'b0, 32'h208, "R5");
    // R6 illegal returns at pointer 3 (owner distance 2)
    retw(32'h4000_1234, 32'hC000_0300, 1'b1, 1'b0, "R6");
    retw(32'h0000_1234, 32'hC000_0304, 1'b1, 1'b0, "R6");
    retw(32'h8000_1234, 32'hC000_0308, 1'b1, 1'b1, "R6");
    retw(32'h8000_1234, 32'hC000_030c, 1'b0, 1'b0, "R6");
    // R7 legal return
    retw(32'h8000_2468, 32'hC000_0100, 1'b1, 1'b0, "R7");
    // R8 underflows of each size
    simple(3'd2, 4'd10, "R10");
    retw(32'hC000_0040, 32'h4000_0400, 1'b1, 1'b0, "R8");
    simple(3'd2, 4'd12, "R10");
    retw(32'h4000_0040, 32'h4000_0404, 1'b1, 1'b0, "R8");
    simple(3'd2, 4'd5, "R10");
    retw(32'h8000_0040, 32'h4000_0408, 1'b1, 1'b0, "R8");
    // R9 allocation checks
    simple(3'd5, 4'd0, "R9");
    simple(3'd2, 4'd10, "R10");
    simple(3'd5, 4'd0, "R9");
    // R10 rotate and restore
    simple(3'd3, 4'd9, "R10");
    simple(3'd4, 4'd14, "R10");
    simple(3'd3, 4'd15, "R10");
    // R12 unknown op codes
    simple(3'd6, 4'd3, "R12");
    simple(3'd7, 4'd3, "R12");

    // R11 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    simple(3'd2, 4'd2, "R11");
    fork
      simple(3'd3, 4'd1, "R11");
      begin
        repeat (4) @(negedge clk);
        #1;
        chk("R11", "rsp_valid held", 32'(rsp_valid), 32'd1);
        chk("R11", "req_ready low", 32'(req_ready), 32'd0);
        chk("R11", "kind held", 32'(rsp_kind), 32'd0);
        chk("R11", "second not taken", 32'(win_base), 32'd2);
        @(negedge clk); rsp_ready = 1'b1;
      end
    join

    repeat (6) @(negedge clk);
    #1;
    chk("R12", "all responses delivered", 32'(sb.size()), 32'd0);
    chk("R11", "idle rsp_valid", 32'(rsp_valid), 32'd0);
    finish_up();
  end

endmodule